// File: doc/BRIEF.md
# Event-Framed Readout FIFO with Token Chain

This block buffers the compressed channel words that a zero-suppression scanner emits for one detector front-end. Each accepted word packs a 12-bit amplitude with the 6-bit number of the channel that produced it. When the scanner reports that an event is complete, the block appends a closing word. That word carries the number of channels that passed the scan and a running 11-bit event number. A side tag bit travels with every stored word and marks closing words, so a reader can find event boundaries without parsing the payload.

Space is guarded by a programmable almost-full level. Once occupancy reaches that level, new channel words are thrown away and a sticky overflow flag is raised. The last free slot is always held back, so the closing word of the current event still fits.

Readout uses a bus that several copies of this block share. A token moves from unit to unit. A unit drives the bus only while it holds the token and has something stored. A unit releases the token one cycle after its closing word is taken. It also releases the token when it runs out of data, or when it receives the token while empty. Words are written and read in the same cycle without disturbing the occupancy count.

Top module: `evt_frame_fifo`

## Requirements
- R1: A channel word accepted while `ch_valid` is high is delivered on `bus_word` as `{ch_amp, ch_addr}`, amplitude in bits 17:6 and channel in bits 5:0, with `bus_last` low. Words leave in the order they were accepted.
- R2: A pulse on `evt_done` stores a closing word `{evt_good, event number}`, good count in bits 17:11 and event number in bits 10:0, which is read out with `bus_last` high. A channel word presented in the same cycle is discarded and does not set `overflow`.
- R3: The event number is 0 after reset and rises by one for every closing word actually stored, wrapping from 2047 to 0. A closing word that finds the memory full is dropped and does not advance the event number.
- R4: `almost_full` is high exactly when the number of stored words is at least the level register. The level register resets to DEPTH-16 (496) and loads `cfg_level` in a cycle with `cfg_we` high.
- R5: A channel word presented while `almost_full` is high is not stored and sets `overflow`. `overflow` stays high until reset.
- R6: A channel word is refused once DEPTH-1 (511) words are stored, even when the level is higher, and that refusal also sets `overflow`. A closing word is stored as long as fewer than DEPTH (512) words are held.
- R7: `bus_oe` is high only while the unit holds the token and is not empty. When `bus_oe` is low, `bus_word` and `bus_last` are 0 and `rd_ack` removes nothing.
- R8: A token arriving on `tok_in` while the unit is empty is returned as a one-cycle `tok_out` pulse in the next cycle, and the bus is not driven.
- R9: When the word taken with `rd_ack` is a closing word, the unit drops `bus_oe` and pulses `tok_out` in the next cycle. The unit also releases the token the same way if it empties while holding it.
- R10: A write and a read in the same cycle leave the occupancy unchanged, so later `almost_full` decisions still match the true word count.
- R11: After reset the unit is empty, does not hold the token, and `bus_oe`, `tok_out`, `almost_full` and `overflow` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the almost-full level |
| cfg_level | input | 10 | New almost-full level in words |
| ch_valid | input | 1 | Channel word present |
| ch_amp | input | 12 | Pedestal-corrected amplitude |
| ch_addr | input | 6 | Channel number |
| evt_done | input | 1 | Event complete; store a closing word |
| evt_good | input | 7 | Number of channels above threshold in the event |
| tok_in | input | 1 | Token pulse from the upstream unit |
| tok_out | output | 1 | Token pulse to the downstream unit |
| rd_ack | input | 1 | Reader takes the word on the bus |
| bus_oe | output | 1 | This unit drives the shared bus |
| bus_word | output | 18 | Head word, zero when not driving |
| bus_last | output | 1 | Head word is a closing word |
| almost_full | output | 1 | Occupancy at or above the level |
| overflow | output | 1 | Sticky: a channel word was discarded for lack of space |

## Verification
The hardest case to reach from the ports is the boundary between the held-back slot and the closing word. It only appears when the almost-full level sits above DEPTH-1, so that the reservation rule acts alone. The stimulus raises the level to 512 and streams 513 channel words with no token present. It then sends one closing word, which should fill the last slot, and a second, which should be lost without moving the event number. Back-to-back reads against back-to-back writes are reached by preloading a few words, handing over the token, and then writing one word per cycle while the reader takes one word per cycle. The word count then stays constant and later almost-full thresholds expose any drift.

// File: rtl/evff_pkg.sv
package evff_pkg;

    // Token ownership of one unit on the shared readout bus
    typedef enum logic {
        TOK_IDLE = 1'b0,
        TOK_HOLD = 1'b1
    } tok_state_e;

endpackage

// File: rtl/evff_store.sv
module evff_store #(
    parameter int W     = 19,
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // head word is visible combinationally so the bus follows the read pointer
    assign rdata = mem[raddr];

endmodule

// File: rtl/evff_writer.sv
module evff_writer #(
    parameter int AMP_W     = 12,
    parameter int CHAN_W    = 6,
    parameter int GOOD_W    = 7,
    parameter int EVT_W     = 11,
    parameter int DEPTH     = 512,
    parameter int AFULL_RST = 496,
    localparam int DATA_W = AMP_W + CHAN_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [OCC_W-1:0]  cfg_level,
    input  logic              ch_valid,
    input  logic [AMP_W-1:0]  ch_amp,
    input  logic [CHAN_W-1:0] ch_addr,
    input  logic              evt_done,
    input  logic [GOOD_W-1:0] evt_good,
    input  logic              pop,
    output logic              push,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [DATA_W:0]   wr_word,
    output logic              empty,
    output logic              almost_full,
    output logic              overflow
);

    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);
    localparam logic [OCC_W-1:0] RSV_OCC  = OCC_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] LVL_RST  = OCC_W'(AFULL_RST);

    typedef struct packed {
        logic [OCC_W-1:0] occ;
        logic [PTR_W-1:0] wptr;
        logic [EVT_W-1:0] evt;
        logic [OCC_W-1:0] level;
        logic             ovf;
    } wr_state_t;

    wr_state_t st_q, st_d;
    logic      push_trl;
    logic      push_dat;
    logic      drop_dat;
    logic      trl_room;
    logic      dat_room;

    always_comb begin
        st_d     = st_q;
        trl_room = (st_q.occ < FULL_OCC);
        dat_room = (st_q.occ < st_q.level) && (st_q.occ < RSV_OCC);
        push_trl = evt_done && trl_room;
        push_dat = ch_valid && !evt_done && dat_room;
        drop_dat = ch_valid && !evt_done && !dat_room;
        push     = push_trl || push_dat;

        if (push_trl) begin
            wr_word = {1'b1, DATA_W'({evt_good, st_q.evt})};
        end else begin
            wr_word = {1'b0, ch_amp, ch_addr};
        end

        if (push) begin
            st_d.wptr = (st_q.wptr == PTR_LAST) ? '0 : st_q.wptr + 1'b1;
        end
        if (push_trl) begin
            st_d.evt = st_q.evt + 1'b1;
        end
        if (drop_dat) begin
            st_d.ovf = 1'b1;
        end
        if (cfg_we) begin
            st_d.level = cfg_level;
        end

        case ({push, pop})
            2'b10:   st_d.occ = st_q.occ + 1'b1;
            2'b01:   st_d.occ = st_q.occ - 1'b1;
            default: st_d.occ = st_q.occ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.occ   <= '0;
            st_q.wptr  <= '0;
            st_q.evt   <= '0;
            st_q.level <= LVL_RST;
            st_q.ovf   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr      = st_q.wptr;
    assign empty       = (st_q.occ == '0);
    assign almost_full = (st_q.occ >= st_q.level);
    assign overflow    = st_q.ovf;

    assert_occ_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= FULL_OCC);

    assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !evt_done && almost_full) |=> overflow);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_evt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && st_q.occ < FULL_OCC) |=> (st_q.evt == $past(st_q.evt) + 1'b1));

    assert_evt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_done && st_q.occ == FULL_OCC) |=> $stable(st_q.evt));

    assert_reserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !evt_done && st_q.occ == RSV_OCC) |=> (st_q.occ <= RSV_OCC));

endmodule

// File: rtl/evff_reader.sv
module evff_reader
    import evff_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_in,
    input  logic              rd_ack,
    input  logic              empty,
    input  logic [DATA_W:0]   head_word,
    output logic              pop,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              tok_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_word,
    output logic              bus_last
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        tok_state_e       tok;
        logic [PTR_W-1:0] rptr;
        logic             pass;
    } rd_state_t;

    rd_state_t st_q, st_d;
    logic      holding;
    logic      head_last;

    assign holding   = (st_q.tok == TOK_HOLD);
    assign head_last = head_word[DATA_W];
    assign bus_oe    = holding && !empty;
    assign pop       = bus_oe && rd_ack;

    always_comb begin
        st_d      = st_q;
        st_d.pass = 1'b0;
        if (pop) begin
            st_d.rptr = (st_q.rptr == PTR_LAST) ? '0 : st_q.rptr + 1'b1;
        end
        case (st_q.tok)
            TOK_IDLE: begin
                if (tok_in) begin
                    if (empty) begin
                        st_d.pass = 1'b1;
                    end else begin
                        st_d.tok = TOK_HOLD;
                    end
                end
            end
            TOK_HOLD: begin
                if (empty || (pop && head_last)) begin
                    st_d.tok  = TOK_IDLE;
                    st_d.pass = 1'b1;
                end
            end
            default: st_d.tok = TOK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tok  <= TOK_IDLE;
            st_q.rptr <= '0;
            st_q.pass <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ptr   = st_q.rptr;
    assign tok_out  = st_q.pass;
    assign bus_word = bus_oe ? head_word[DATA_W-1:0] : '0;
    assign bus_last = bus_oe && head_last;

    assert_empty_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tok == TOK_IDLE && tok_in && empty) |=> tok_out);

    assert_last_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && head_last) |=> (tok_out && !bus_oe));

    assert_quiet_after_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |-> !bus_oe);

    assert_no_silent_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |=> (st_q.rptr == $past(st_q.rptr)));

endmodule

// File: rtl/evt_frame_fifo.sv
module evt_frame_fifo #(
    parameter int AMP_W     = 12,
    parameter int CHAN_W    = 6,
    parameter int GOOD_W    = 7,
    parameter int EVT_W     = 11,
    parameter int DEPTH     = 512,
    parameter int AFULL_RST = 496,
    localparam int DATA_W = AMP_W + CHAN_W,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic              ch_valid,
    input  logic [AMP_W-1:0]  ch_amp,
    input  logic [CHAN_W-1:0] ch_addr,
    input  logic              evt_done,
    input  logic [GOOD_W-1:0] evt_good,
    input  logic              tok_in,
    output logic              tok_out,
    input  logic              rd_ack,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_word,
    output logic              bus_last,
    output logic              almost_full,
    output logic              overflow
);

    logic             push;
    logic             pop;
    logic             empty;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [DATA_W:0]  wr_word;
    logic [DATA_W:0]  head_word;

    evff_writer #(
        .AMP_W(AMP_W), .CHAN_W(CHAN_W), .GOOD_W(GOOD_W), .EVT_W(EVT_W),
        .DEPTH(DEPTH), .AFULL_RST(AFULL_RST)
    ) u_writer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
        .ch_valid(ch_valid), .ch_amp(ch_amp), .ch_addr(ch_addr),
        .evt_done(evt_done), .evt_good(evt_good), .pop(pop),
        .push(push), .wr_ptr(wr_ptr), .wr_word(wr_word), .empty(empty),
        .almost_full(almost_full), .overflow(overflow)
    );

    evff_store #(.W(DATA_W + 1), .DEPTH(DEPTH)) u_store (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata(wr_word),
        .raddr(rd_ptr), .rdata(head_word)
    );

    evff_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_reader (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .rd_ack(rd_ack),
        .empty(empty), .head_word(head_word), .pop(pop), .rd_ptr(rd_ptr),
        .tok_out(tok_out), .bus_oe(bus_oe), .bus_word(bus_word), .bus_last(bus_last)
    );

endmodule

// File: tb/sim_evt_frame_fifo.sv
`timescale 1ns/1ps
module sim_evt_frame_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_level = '0;
    logic        ch_valid = 1'b0;
    logic [11:0] ch_amp = '0;
    logic [5:0]  ch_addr = '0;
    logic        evt_done = 1'b0;
    logic [6:0]  evt_good = '0;
    logic        tok_in = 1'b0;
    logic        tok_out;
    logic        rd_ack;
    logic        bus_oe;
    logic [17:0] bus_word;
    logic        bus_last;
    logic        almost_full;
    logic        overflow;

    logic        mon_ack = 1'b0;
    logic        force_ack = 1'b0;
    assign rd_ack = mon_ack | force_ack;

    always #10 clk = ~clk;

    evt_frame_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_level(cfg_level),
        .ch_valid(ch_valid), .ch_amp(ch_amp), .ch_addr(ch_addr),
        .evt_done(evt_done), .evt_good(evt_good), .tok_in(tok_in), .tok_out(tok_out),
        .rd_ack(rd_ack), .bus_oe(bus_oe), .bus_word(bus_word), .bus_last(bus_last),
        .almost_full(almost_full), .overflow(overflow)
    );

    logic [18:0] expq[$];
    int          total = 0;
    int          bad = 0;
    int          pass_cnt = 0;
    logic        expect_pass = 1'b0;
    logic [10:0] exp_evt = '0;
    logic        done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: takes every driven word and compares it with the scoreboard
    always @(negedge clk) begin : monitor
        logic [18:0] got;
        logic [18:0] want;
        if (rst_n) begin
            if (tok_out) pass_cnt++;
            if (expect_pass) begin
                chk(tok_out && !bus_oe, "R9 token pass after closing word",
                    {tok_out, bus_oe}, 2'b10);
                expect_pass = 1'b0;
            end
            if (bus_oe) begin
                got = {bus_last, bus_word};
                if (expq.size() == 0) begin
                    chk(1'b0, "R1 unexpected word on bus", got, 0);
                end else begin
                    want = expq.pop_front();
                    chk(got == want, want[18] ? "R2 closing word" : "R1 data word", got, want);
                    if (want[18]) expect_pass = 1'b1;
                end
                mon_ack <= 1'b1;
            end else begin
                mon_ack <= 1'b0;
            end
        end else begin
            mon_ack <= 1'b0;
            expect_pass = 1'b0;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        ch_valid = 1'b0;
        evt_done = 1'b0;
        tok_in = 1'b0;
        cfg_we = 1'b0;
        force_ack = 1'b0;
        expq.delete();
        exp_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_word(input logic [11:0] amp, input logic [5:0] ch, input bit keep);
        ch_valid = 1'b1;
        ch_amp = amp;
        ch_addr = ch;
        if (keep) expq.push_back({1'b0, amp, ch});
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    task automatic put_trailer(input logic [6:0] good, input bit keep, input bit with_ch);
        evt_done = 1'b1;
        evt_good = good;
        if (with_ch) begin
            ch_valid = 1'b1;
            ch_amp = 12'hABC;
            ch_addr = 6'h15;
        end
        if (keep) begin
            expq.push_back({1'b1, good, exp_evt});
            exp_evt = exp_evt + 1'b1;
        end
        @(negedge clk);
        evt_done = 1'b0;
        ch_valid = 1'b0;
    endtask

    task automatic set_level(input logic [9:0] v);
        cfg_we = 1'b1;
        cfg_level = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic give_token();
        tok_in = 1'b1;
        @(negedge clk);
        tok_in = 1'b0;
    endtask

    task automatic wait_pass(input int start, input string tag);
        int n = 0;
        while (pass_cnt <= start && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(pass_cnt > start, tag, pass_cnt, start + 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        int s;
        do_reset();

        // R11 reset state
        chk(!bus_oe && !tok_out && bus_word == 0 && !bus_last, "R11 bus idle after reset",
            {bus_oe, tok_out, bus_last, bus_word}, 0);
        chk(!almost_full && !overflow, "R11 flags low after reset", {almost_full, overflow}, 0);

        // R1/R2: five words, closing word overlapping a channel word
        for (int i = 0; i < 5; i++) put_word(12'(100 + i * 7), 6'(i + 3), 1'b1);
        put_trailer(7'd5, 1'b1, 1'b1);
        chk(!overflow, "R2 overlapped channel word does not flag overflow", overflow, 0);
        s = pass_cnt;
        give_token();
        wait_pass(s, "R9 token returned after event");
        chk(expq.size() == 0, "R1 all words delivered", expq.size(), 0);

        // R7: no token, data present, acks must not remove anything
        for (int i = 0; i < 3; i++) put_word(12'(2000 + i), 6'(40 + i), 1'b1);
        chk(!bus_oe && bus_word == 0 && !bus_last, "R7 bus quiet without token",
            {bus_oe, bus_last, bus_word}, 0);
        force_ack = 1'b1;
        repeat (3) @(negedge clk);
        force_ack = 1'b0;
        s = pass_cnt;
        give_token();
        wait_pass(s, "R9 token released on running empty");
        chk(expq.size() == 0, "R7 stray acks removed nothing", expq.size(), 0);

        // R8: token into an empty unit
        give_token();
        chk(tok_out && !bus_oe, "R8 empty unit passes token next cycle", {tok_out, bus_oe}, 2'b10);
        @(negedge clk);
        chk(!tok_out, "R8 token pass is one cycle", tok_out, 0);

        // R10: concurrent writes and reads
        for (int i = 0; i < 4; i++) put_word(12'(300 + i), 6'(i), 1'b1);
        s = pass_cnt;
        give_token();
        for (int i = 0; i < 20; i++) put_word(12'(500 + i * 3), 6'(10 + i), 1'b1);
        put_trailer(7'd24, 1'b1, 1'b0);
        wait_pass(s, "R10 token returned after concurrent event");
        set_level(10'd3);
        put_word(12'h111, 6'd1, 1'b1);
        put_word(12'h222, 6'd2, 1'b1);
        chk(!almost_full, "R10 R4 two words below level three", almost_full, 0);
        put_word(12'h333, 6'd3, 1'b1);
        chk(almost_full, "R10 R4 three words reach level three", almost_full, 1);
        s = pass_cnt;
        give_token();
        wait_pass(s, "R9 token after draining partial event");

        // R4/R5: level four, six words offered
        set_level(10'd4);
        for (int i = 0; i < 4; i++) put_word(12'(700 + i), 6'(20 + i), 1'b1);
        chk(almost_full && !overflow, "R4 level reached without loss",
            {almost_full, overflow}, 2'b10);
        put_word(12'd800, 6'd30, 1'b0);
        chk(overflow, "R5 dropped word sets overflow", overflow, 1);
        put_word(12'd801, 6'd31, 1'b0);
        put_trailer(7'd6, 1'b1, 1'b0);
        s = pass_cnt;
        give_token();
        wait_pass(s, "R9 token after clipped event");
        chk(overflow && !almost_full, "R5 overflow sticky after drain",
            {overflow, almost_full}, 2'b10);

        // R6: reservation with level above the depth
        do_reset();
        set_level(10'd512);
        for (int i = 0; i < 513; i++) put_word(12'(i), 6'(i), i < 511);
        chk(overflow && !almost_full, "R6 word refused at 511 stored",
            {overflow, almost_full}, 2'b10);
        put_trailer(7'd9, 1'b1, 1'b0);
        chk(almost_full, "R6 closing word fills last slot", almost_full, 1);
        put_trailer(7'd10, 1'b0, 1'b0);
        s = pass_cnt;
        give_token();
        wait_pass(s, "R6 token after full drain");
        put_trailer(7'd11, 1'b1, 1'b0);
        s = pass_cnt;
        give_token();
        wait_pass(s, "R3 token after event number check");

        // R3: event number wrap
        do_reset();
        for (int k = 0; k < 2049; k++) begin
            put_trailer(7'(k), 1'b1, 1'b0);
            s = pass_cnt;
            give_token();
            wait_pass(s, "R3 token during wrap run");
        end
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R3 all closing words delivered", expq.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule